// File: doc/BRIEF.md
# Daisy-Chain Register Write Sequencer

This block runs on the host side and programs the configuration registers of a chain of serially linked converters. It drives a serial clock, a data-in line and a convert line. The convert line stays low for the whole operation, so the converters treat the traffic as a register write. Each write word is a command byte followed by a register data byte. The host shifts words MSB first into the first device in the chain. Each device samples its data input on the rising serial clock edge and passes older bits on toward the far end of the chain.

There are two modes. A broadcast write sends one frame of 8 × (N + 1) clocks, so every device ends up holding the same command and data. An individual write sends N frames, one per device. The first frame targets the device furthest from the host. Each later frame is 8 clocks shorter, and the last frame is 16 clocks long and reaches only the nearest device. The word always leads its frame and zero padding follows it. The padding sets how far the word travels down the chain. The serial clock rests low for a programmable gap between frames. A one-cycle done pulse marks the end of the whole sequence.

Top module: `dchain_wr_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, `ser_clk`, `ser_din`, `busy` and `done` are all low. A reset asserted in the middle of a sequence stops it at once.
- R2: A `start` pulse seen while idle begins a sequence, and `busy` is high in the cycle after `start` was sampled. A `start` pulse seen while busy is ignored.
- R3: `ser_din` changes only while `ser_clk` is low. Each frame carries `cmd_byte` bit 7 down to bit 0, then the selected data byte bit 7 down to bit 0, then zeros to the end of the frame.
- R4: With `indiv_mode` = 0, the sequence is a single frame of 8 × (N_DEV + 1) rising serial clock edges, and its data byte is slot 0 (`reg_values[7:0]`).
- R5: With `indiv_mode` = 1, the sequence is N_DEV frames. Frame k (k = 0 first) has 8 × (N_DEV + 1 − k) rising edges and carries slot N_DEV − 1 − k, where slot i is `reg_values[8*i+7:8*i]` and slot 0 belongs to the device nearest the host.
- R6: Within a frame, rising edges are 2·HALF system clocks apart. Between frames, `ser_clk` and `ser_din` stay low, and the spacing between the last rising edge of one frame and the first rising edge of the next is 2·HALF + 1 + `gap_cycles` system clocks.
- R7: After the final frame, `done` is high for exactly one cycle, and `busy` is low in that same cycle.
- R8: `conv` is held low at all times.
- R9: The mode, command, data and gap inputs are captured at start. Changing them during a sequence has no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a write sequence (honoured only when idle) |
| indiv_mode | input | 1 | 0 = broadcast one word, 1 = distinct word per device |
| cmd_byte | input | 8 | Command byte sent ahead of each data byte |
| reg_values | input | 8·N_DEV | Per-device data bytes, slot 0 nearest the host |
| gap_cycles | input | GAP_W | Idle system cycles inserted between individual frames |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse after the last frame |
| ser_clk | output | 1 | Serial clock to the chain, idle low |
| ser_din | output | 1 | Serial data to the first device's data input |
| conv | output | 1 | Convert line, held low |

## Verification
Some properties are checked by assertions on every cycle:
- `ser_din` never moves while `ser_clk` is high.
- The lines stay quiet whenever the block is idle.
- No serial clock edge occurs during an inter-frame gap.
- Each frame ends after exactly the number of rising edges its length calls for.
- `done` never lasts two cycles.
- Captured settings hold still while busy.

The bench scenarios cover what the assertions cannot. The bench rebuilds the frame stream from the pins and checks the slot order of individual writes, the zero padding and the shrinking frame lengths. It also measures the gap spacing for several gap values, checks that a second start and input changes made mid-run leave the stream untouched, and applies a reset in the middle of a run.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } dcw_state_e;

  // Number of serial clocks in frame k of a sequence.
  function automatic int unsigned dcw_frame_len(input logic indiv,
                                                input int unsigned ndev,
                                                input int unsigned k);
    if (indiv) return BYTE_W * (ndev + 1 - k);
    return BYTE_W * (ndev + 1);
  endfunction

  // Bit sent at position idx of a frame: command, data, then zero padding.
  function automatic logic dcw_frame_bit(input logic [BYTE_W-1:0] cmd,
                                         input logic [BYTE_W-1:0] dat,
                                         input int unsigned idx);
    logic [2*BYTE_W-1:0] word;
    word = {cmd, dat};
    if (idx < 2 * BYTE_W) return word[4'(2 * BYTE_W - 1 - idx)];
    return 1'b0;
  endfunction

endpackage

// File: rtl/dcw_sclk_gen.sv
module dcw_sclk_gen #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int unsigned PH_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [PH_W-1:0] ph;
  logic            tick;

  always_comb begin
    tick     = run && (ph == PH_W'(HALF - 1));
    rise_evt = tick && !sclk;
    fall_evt = tick && sclk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      ph   <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      ph   <= '0;
      sclk <= ~sclk;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  AST_EDGE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $past(run)) else $error("sclk rose while stopped"); // R6

endmodule

// File: rtl/dcw_frame_ctrl.sv
module dcw_frame_ctrl
  import dcw_pkg::*;
#(
  parameter int unsigned N_DEV = 4,
  parameter int unsigned GAP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     indiv,
  input  logic [BYTE_W-1:0]        cmd,
  input  logic [N_DEV*BYTE_W-1:0]  data_flat,
  input  logic [GAP_W-1:0]         gap,
  input  logic                     rise_evt,
  input  logic                     fall_evt,
  output logic                     run,
  output logic                     sdi,
  output logic                     busy,
  output logic                     done
);
  localparam int unsigned MAX_LEN = BYTE_W * (N_DEV + 1);
  localparam int unsigned BIT_W   = $clog2(MAX_LEN + 1);
  localparam int unsigned IDX_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1;

  dcw_state_e        st;
  logic              mode_q;
  logic [BYTE_W-1:0] cmd_q;
  logic [BYTE_W-1:0] data_q [N_DEV];
  logic [GAP_W-1:0]  gap_q, gcnt;
  logic [IDX_W-1:0]  fidx, slot;
  logic [BIT_W-1:0]  bidx, rcnt, cur_len;
  logic [BYTE_W-1:0] cur_dat;
  logic              last_bit, last_frame, frame_end_evt;

  always_comb begin
    slot          = mode_q ? (IDX_W'(N_DEV - 1) - fidx) : '0;
    cur_dat       = data_q[slot];
    cur_len       = BIT_W'(dcw_frame_len(mode_q, N_DEV, 32'(fidx)));
    last_bit      = (bidx == cur_len - 1'b1);
    last_frame    = !mode_q || (fidx == IDX_W'(N_DEV - 1));
    frame_end_evt = fall_evt && last_bit;
    run           = (st == ST_SHIFT);
    busy          = (st != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      mode_q <= 1'b0;
      cmd_q  <= '0;
      gap_q  <= '0;
      gcnt   <= '0;
      fidx   <= '0;
      bidx   <= '0;
      rcnt   <= '0;
      sdi    <= 1'b0;
      done   <= 1'b0;
      for (int i = 0; i < int'(N_DEV); i++) data_q[i] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          mode_q <= indiv;
          cmd_q  <= cmd;
          gap_q  <= gap;
          for (int i = 0; i < int'(N_DEV); i++)
            data_q[i] <= data_flat[i*BYTE_W +: BYTE_W];
          fidx <= '0;
          bidx <= '0;
          rcnt <= '0;
          sdi  <= cmd[BYTE_W-1];
          st   <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (rise_evt) rcnt <= rcnt + 1'b1;
          if (fall_evt) begin
            if (last_bit) begin
              sdi <= 1'b0;
              if (last_frame) begin
                st   <= ST_IDLE;
                done <= 1'b1;
              end else begin
                st   <= ST_GAP;
                gcnt <= gap_q;
                fidx <= fidx + 1'b1;
              end
            end else begin
              bidx <= bidx + 1'b1;
              sdi  <= dcw_frame_bit(cmd_q, cur_dat, 32'(bidx) + 1);
            end
          end
        end
        ST_GAP: begin
          if (gcnt == '0) begin
            st   <= ST_SHIFT;
            bidx <= '0;
            rcnt <= '0;
            sdi  <= cmd_q[BYTE_W-1];
          end else begin
            gcnt <= gcnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_evt |-> (rcnt == cur_len)) else $error("frame edge count"); // R5
  AST_GAP_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP) |-> !rise_evt && !fall_evt) else $error("edge in gap"); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done too long"); // R7
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mode_q) && $stable(cmd_q) && $stable(gap_q)))
    else $error("captured setting moved"); // R9

endmodule

// File: rtl/dchain_wr_seq.sv
module dchain_wr_seq
  import dcw_pkg::*;
#(
  parameter int unsigned N_DEV = 4,
  parameter int unsigned HALF  = 2,
  parameter int unsigned GAP_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    indiv_mode,
  input  logic [7:0]              cmd_byte,
  input  logic [N_DEV*8-1:0]      reg_values,
  input  logic [GAP_W-1:0]        gap_cycles,
  output logic                    busy,
  output logic                    done,
  output logic                    ser_clk,
  output logic                    ser_din,
  output logic                    conv
);
  logic run_w, rise_w, fall_w;

  dcw_sclk_gen #(.HALF(HALF)) u_sclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .sclk     (ser_clk),
    .rise_evt (rise_w),
    .fall_evt (fall_w)
  );

  dcw_frame_ctrl #(.N_DEV(N_DEV), .GAP_W(GAP_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .indiv     (indiv_mode),
    .cmd       (cmd_byte),
    .data_flat (reg_values),
    .gap       (gap_cycles),
    .rise_evt  (rise_w),
    .fall_evt  (fall_w),
    .run       (run_w),
    .sdi       (ser_din),
    .busy      (busy),
    .done      (done)
  );

  assign conv = 1'b0;

  AST_DIN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_din != $past(ser_din)) |-> !ser_clk) else $error("din moved high"); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_din)) else $error("lines active idle"); // R1

endmodule

// File: tb/sim_dchain_wr_seq.sv
module sim_dchain_wr_seq;
  localparam int N    = 4;
  localparam int HALF = 2;
  localparam int GW   = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, indiv = 1'b0;
  logic [7:0] cmd = '0;
  logic [N*8-1:0] vals = '0;
  logic [GW-1:0] gap = '0;
  logic busy, done, ser_clk, ser_din, conv;

  always #10 clk = ~clk;

  dchain_wr_seq #(.N_DEV(N), .HALF(HALF), .GAP_W(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .indiv_mode(indiv),
    .cmd_byte(cmd), .reg_values(vals), .gap_cycles(gap),
    .busy(busy), .done(done), .ser_clk(ser_clk), .ser_din(ser_din), .conv(conv));

  int total = 0, bad = 0;
  int rise_t [256];
  bit rise_v [256];
  int nr;

  // {indiv, cmd, slots 3..0, gap}
  localparam logic [48:0] VEC [6] = '{
    {1'b0, 8'hA5, 32'h000000C3, 8'd0},
    {1'b1, 8'h14, 32'h44332211, 8'd0},
    {1'b1, 8'hF0, 32'hDEADBEEF, 8'd5},
    {1'b0, 8'h00, 32'h123456FF, 8'd3},
    {1'b1, 8'hFF, 32'h00FF0000, 8'd1},
    {1'b1, 8'h81, 32'h7E01807F, 8'd9}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_seq(input logic [48:0] v, input bit disturb);
    bit m; logic [7:0] c; logic [31:0] d; int g;
    int t, cnv_bad, nfd, pos;
    bit prev, seen;
    int fs [8]; int fl [8]; int bnd [8];
    m = v[48]; c = v[47:40]; d = v[39:8]; g = int'(v[7:0]);
    @(negedge clk);
    indiv = m; cmd = c; vals = d; gap = v[7:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    prev = 0; nr = 0; cnv_bad = 0; t = 0; seen = 0;
    while (!seen && t < 4000) begin
      if (conv) cnv_bad++;
      if (ser_clk && !prev && nr < 256) begin
        rise_t[nr] = t; rise_v[nr] = ser_din; nr++;
      end
      prev = ser_clk;
      if (done) seen = 1;
      else begin
        if (disturb && t == 30) begin
          start = 1'b1; indiv = ~m; cmd = ~c; vals = ~d; gap = 8'd40;
        end
        if (disturb && t == 31) start = 1'b0;
        @(negedge clk);
        t++;
      end
    end
    chk(seen, "R7 done reached", seen, 1);
    chk(busy == 1'b0, "R7 busy low with done", busy, 0);
    chk(cnv_bad == 0, "R8 conv low", cnv_bad, 0);
    // split captured edges into frames by spacing
    nfd = 0;
    for (int i = 0; i < nr; i++) begin
      if (i == 0 || rise_t[i] - rise_t[i-1] != 2 * HALF) begin
        if (nfd < 8) begin
          fs[nfd] = i; fl[nfd] = 0;
          bnd[nfd] = (i == 0) ? 0 : rise_t[i] - rise_t[i-1];
        end
        nfd++;
      end
      if (nfd <= 8) fl[nfd-1]++;
    end
    if (m) chk(nfd == N, "R5 frame count", nfd, N);
    else   chk(nfd == 1, "R4 frame count", nfd, 1);
    for (int f = 0; f < nfd && f < 8 && f < (m ? N : 1); f++) begin
      int elen, slot, errs;
      logic [15:0] word;
      elen = m ? 8 * (N + 1 - f) : 8 * (N + 1);
      slot = m ? N - 1 - f : 0;
      word = {c, d[8*slot +: 8]};
      chk(fl[f] == elen, m ? "R5 frame length" : "R4 frame length", fl[f], elen);
      errs = 0;
      for (int j = 0; j < fl[f]; j++) begin
        pos = fs[f] + j;
        if (rise_v[pos] != ((j < 16) ? word[15 - j] : 1'b0)) errs++;
      end
      chk(errs == 0, "R3 frame bits", errs, 0);
      if (f > 0) chk(bnd[f] == 2 * HALF + 1 + g, "R6 gap spacing", bnd[f], 2 * HALF + 1 + g);
    end
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    chk(!ser_clk && !ser_din && !busy, "R1 idle quiet", {ser_clk, ser_din, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ser_clk && !ser_din && !conv, "R1 reset state",
        {busy, done, ser_clk, ser_din, conv}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 6; k++) run_seq(VEC[k], 1'b0);
    // R2 / R9: restart and input changes during a run have no effect
    run_seq({1'b1, 8'h3C, 32'hA1B2C3D4, 8'd2}, 1'b1);
    run_seq({1'b0, 8'h96, 32'h0000005A, 8'd0}, 1'b1);
    // R1: reset mid-sequence stops everything
    @(negedge clk);
    indiv = 1'b1; cmd = 8'hFF; vals = '1; gap = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !ser_clk && !ser_din, "R1 reset mid-run",
        {busy, done, ser_clk, ser_din}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!busy && !ser_clk, "R2 no self restart", {busy, ser_clk}, 0);
    run_seq(VEC[1], 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule